// File: doc/BRIEF.md
# Register-Array Microoperation Datapath

This block is the execution slice of a small register-transfer datapath. It keeps four 8-bit registers. One control word selects two source registers, a functional block, that block's mode and one destination register. The register file feeds two read multiplexers. The first operand goes to a single-register unit, which performs load-immediate, copy, shift, complement, mask and rotate. Both operands go to an adder-subtractor. A block-select bit picks which of the two results drives the shared write bus.

The destination address is decoded into per-register enables, and these are gated by a write-enable input. At most one register captures the result bus on each rising clock edge. The result, the carry-out and both read-mux outputs are combinational functions of the current control word and register contents. A sequencer can therefore see the outcome of an operation in the same cycle it issues it.

Top module: `regarray_dp`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four registers to 0x00, and it takes priority over any write in the same cycle.
- R2: With `wr_en` high, the rising edge loads `result` into the register addressed by `dst` only. The other three registers keep their values.
- R3: With `wr_en` low, no register changes at the clock edge, whatever the rest of the control word holds.
- R4: `op_a` shows the register addressed by `src_a` and `op_b` shows the one addressed by `src_b`, independently and in the same cycle, including when both addresses are equal.
- R5: Single-register unit (`blk_sel`=0), mode 0: the result is the 8-bit immediate `imm`.
- R6: Mode 1 copies `op_a` unchanged. Modes 6 and 7 are unused codes and behave as mode 1.
- R7: Mode 2 shifts `op_a` by one bit, left when `dir`=0 and right when `dir`=1. The vacated bit is filled with 0.
- R8: Mode 3 gives the bitwise complement of `op_a`.
- R9: Mode 4 gives `op_a` bitwise AND `imm`.
- R10: Mode 5 rotates `op_a` by one bit, left when `dir`=0 (bit 7 enters bit 0) and right when `dir`=1 (bit 0 enters bit 7).
- R11: Adder-subtractor (`blk_sel`=1). `mode[0]`=0 gives `op_a`+`op_b`. `mode[0]`=1 gives `op_a`+~`op_b`+1. The result wraps modulo 256, and `carry` is the ninth bit of that sum.
- R12: `blk_sel` alone decides which block drives `result`. With `blk_sel`=1, `imm` and `dir` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Gates the destination decoder |
| src_a | input | 2 | First source register address |
| src_b | input | 2 | Second source register address |
| dst | input | 2 | Destination register address |
| blk_sel | input | 1 | 0 = single-register unit, 1 = adder-subtractor |
| mode | input | 3 | Operation code for the selected block |
| dir | input | 1 | Shift and rotate direction, 0 = left, 1 = right |
| imm | input | 8 | Immediate value or AND mask |
| op_a | output | 8 | First read-mux output |
| op_b | output | 8 | Second read-mux output |
| result | output | 8 | Write bus value |
| carry | output | 1 | Adder-subtractor carry-out |

## Verification
On every cycle, the assertions check the write-port discipline. They check that a disabled write leaves the whole array stable, that an enabled write lands the previous cycle's bus value in the addressed register, and that every other register holds. They also tie the adder-subtractor result and carry to the read-mux outputs, and tie complement mode to the first operand. The per-mode arithmetic of shift, rotate, mask, immediate and copy is covered only by the bench scenarios. So are the precedence of reset over a write, the boundary patterns (0x81 rotations, 0xFF+0x01 wrap, a register minus itself) and the fact that the unused codes act as copy. In those scenarios, each write is followed by read-back of the registers through the read multiplexers.

// File: rtl/regarray_dp.sv
module regarray_dp #(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [AW-1:0] dst,
  input  logic          blk_sel,
  input  logic [2:0]    mode,
  input  logic          dir,
  input  logic [W-1:0]  imm,
  output logic [W-1:0]  op_a,
  output logic [W-1:0]  op_b,
  output logic [W-1:0]  result,
  output logic          carry
);

  localparam logic [2:0] M_IMM = 3'd0;
  localparam logic [2:0] M_CPY = 3'd1;
  localparam logic [2:0] M_SHF = 3'd2;
  localparam logic [2:0] M_INV = 3'd3;
  localparam logic [2:0] M_MSK = 3'd4;
  localparam logic [2:0] M_ROT = 3'd5;

  logic [NREG-1:0][W-1:0] rf;
  logic [NREG-1:0]        wen;
  logic [W-1:0]           unit_res;
  logic [W:0]             sum;
  logic                   sub;

  assign op_a = rf[src_a];
  assign op_b = rf[src_b];

  always_comb begin
    case (mode)
      M_IMM:   unit_res = imm;
      M_CPY:   unit_res = op_a;
      M_SHF:   unit_res = dir ? {1'b0, op_a[W-1:1]} : {op_a[W-2:0], 1'b0};
      M_INV:   unit_res = ~op_a;
      M_MSK:   unit_res = op_a & imm;
      M_ROT:   unit_res = dir ? {op_a[0], op_a[W-1:1]} : {op_a[W-2:0], op_a[W-1]};
      default: unit_res = op_a;
    endcase
  end

  assign sub    = mode[0];
  assign sum    = {1'b0, op_a} + {1'b0, op_b ^ {W{sub}}} + (W+1)'(sub);
  assign carry  = sum[W];
  assign result = blk_sel ? sum[W-1:0] : unit_res;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wen[i] = wr_en && (dst == AW'(i));
    always_ff @(posedge clk) begin
      if (rst)         rf[i] <= '0;
      else if (wen[i]) rf[i] <= result;
    end
  end

endmodule

// File: rtl/regarray_dp_chk.sv
module regarray_dp_chk #(
  parameter int W    = 8,
  parameter int NREG = 4,
  parameter int AW   = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [AW-1:0]          dst,
  input logic                   blk_sel,
  input logic [2:0]             mode,
  input logic [W-1:0]           op_a,
  input logic [W-1:0]           op_b,
  input logic [W-1:0]           result,
  input logic                   carry,
  input logic [NREG-1:0][W-1:0] rf
);

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rf));

  // R2
  dst_captures_bus_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rf[$past(dst)] == $past(result));

  for (genvar i = 0; i < NREG; i++) begin : g_keep
    // R2
    other_reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && dst != AW'(i)) |=> $stable(rf[i]));
  end

  // R11
  add_path_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_sel && !mode[0]) |-> {carry, result} == ({1'b0, op_a} + {1'b0, op_b}));

  // R11
  sub_path_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_sel && mode[0]) |-> {carry, result} == ({1'b0, op_a} + {1'b0, ~op_b} + (W+1)'(1)));

  // R8
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    (!blk_sel && mode == 3'd3) |-> result == ~op_a);

endmodule

bind regarray_dp regarray_dp_chk #(.W(W), .NREG(NREG), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .dst(dst), .blk_sel(blk_sel),
  .mode(mode), .op_a(op_a), .op_b(op_b), .result(result), .carry(carry),
  .rf(rf)
);

// File: tb/regarray_dp_bench.sv
module regarray_dp_bench;
  localparam int CLK_P = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [1:0] src_a = 0, src_b = 0, dst = 0;
  logic       blk_sel = 0;
  logic [2:0] mode = 0;
  logic       dir = 0;
  logic [7:0] imm = 0;
  logic [7:0] op_a, op_b, result;
  logic       carry;

  regarray_dp u_regarray_dp (
    .clk(clk), .rst(rst), .wr_en(wr_en), .src_a(src_a), .src_b(src_b),
    .dst(dst), .blk_sel(blk_sel), .mode(mode), .dir(dir), .imm(imm),
    .op_a(op_a), .op_b(op_b), .result(result), .carry(carry)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [7:0] res;
    logic       cy;
    bit         chk_cy;
    logic [7:0] a;
    logic [7:0] b;
    string      tag;
  } exp_t;

  exp_t       sbq[$];
  logic [7:0] mdl [4];
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;

  function automatic exp_t model(input logic [1:0] sa, input logic [1:0] sb,
                                 input logic blk, input logic [2:0] md,
                                 input logic dr, input logic [7:0] im, input string tag);
    exp_t e;
    logic [8:0] s;
    logic [7:0] a = mdl[sa];
    logic [7:0] b = mdl[sb];
    e.a = a; e.b = b; e.tag = tag; e.chk_cy = blk; e.cy = 0;
    if (blk) begin
      s = md[0] ? ({1'b0, a} + {1'b0, ~b} + 9'd1) : ({1'b0, a} + {1'b0, b});
      e.res = s[7:0];
      e.cy  = s[8];
    end else begin
      case (md)
        3'd0: e.res = im;
        3'd2: e.res = dr ? (a >> 1) : (a << 1);
        3'd3: e.res = ~a;
        3'd4: e.res = a & im;
        3'd5: e.res = dr ? {a[0], a[7:1]} : {a[6:0], a[7]};
        default: e.res = a;
      endcase
    end
    return e;
  endfunction

  task automatic step(input logic [1:0] sa, input logic [1:0] sb, input logic [1:0] d,
                      input logic blk, input logic [2:0] md, input logic dr,
                      input logic [7:0] im, input logic we, input string tag);
    exp_t e;
    @(negedge clk);
    src_a = sa; src_b = sb; dst = d; blk_sel = blk; mode = md; dir = dr;
    imm = im; wr_en = we;
    e = model(sa, sb, blk, md, dr, im, tag);
    sbq.push_back(e);
    if (we) mdl[d] = e.res;
  endtask

  task automatic rd(input logic [1:0] r, input string tag);
    step(r, r, 2'd0, 1'b0, 3'd1, 1'b0, 8'h00, 1'b0, tag);
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 4; i++) rd(2'(i), tag);
  endtask

  task automatic do_reset(input logic we);
    @(negedge clk);
    rst = 1; wr_en = we; blk_sel = 0; mode = 3'd0; imm = 8'hEE; dst = 2'd2;
    @(negedge clk);
    rst = 0; wr_en = 0;
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        n_chk++;
        if (result !== e.res || (e.chk_cy && carry !== e.cy)) begin
          n_err++;
          $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                   e.tag, result, carry, e.res, e.cy);
        end
        n_chk++;
        if (op_a !== e.a || op_b !== e.b) begin
          n_err++;
          $display("FAIL R4 (%s): op_a=%h op_b=%h expected op_a=%h op_b=%h",
                   e.tag, op_a, op_b, e.a, e.b);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 4; i++) mdl[i] = 8'hXX;
    do_reset(1'b0);
    rd_all("R1");
    step(0, 0, 0, 0, 3'd0, 0, 8'hA5, 1, "R5");
    step(0, 0, 1, 0, 3'd0, 0, 8'h3C, 1, "R5");
    step(0, 0, 2, 0, 3'd0, 0, 8'h81, 1, "R5");
    step(0, 0, 3, 0, 3'd0, 0, 8'hFF, 1, "R5");
    rd_all("R2");
    step(0, 0, 1, 0, 3'd0, 0, 8'h00, 0, "R3");
    step(2, 0, 3, 0, 3'd3, 0, 8'h00, 0, "R3");
    rd_all("R3");
    step(0, 1, 2, 0, 3'd1, 0, 8'h00, 1, "R6");
    rd_all("R2");
    step(1, 0, 0, 0, 3'd6, 0, 8'h55, 0, "R6");
    step(3, 0, 0, 0, 3'd7, 1, 8'h55, 0, "R6");
    step(2, 0, 2, 0, 3'd2, 0, 8'h00, 1, "R7");
    step(3, 0, 3, 0, 3'd2, 1, 8'h00, 1, "R7");
    step(2, 0, 1, 0, 3'd2, 1, 8'h00, 1, "R7");
    rd_all("R7");
    step(1, 0, 1, 0, 3'd3, 0, 8'h00, 1, "R8");
    step(3, 0, 3, 0, 3'd4, 0, 8'h0F, 1, "R9");
    step(0, 0, 0, 0, 3'd4, 0, 8'hF0, 0, "R9");
    step(0, 0, 2, 0, 3'd0, 0, 8'h81, 1, "R5");
    step(2, 0, 0, 0, 3'd5, 0, 8'h00, 0, "R10");
    step(2, 0, 0, 0, 3'd5, 1, 8'h00, 0, "R10");
    step(2, 0, 2, 0, 3'd5, 0, 8'h00, 1, "R10");
    rd(2, "R10");
    step(0, 0, 0, 0, 3'd0, 0, 8'hFF, 1, "R5");
    step(0, 0, 1, 0, 3'd0, 0, 8'h01, 1, "R5");
    step(0, 1, 2, 1, 3'd0, 0, 8'h00, 1, "R11");
    rd(2, "R11");
    step(0, 0, 0, 0, 3'd0, 0, 8'h05, 1, "R5");
    step(0, 0, 1, 0, 3'd0, 0, 8'h03, 1, "R5");
    step(0, 1, 3, 1, 3'd1, 0, 8'h00, 1, "R11");
    step(1, 0, 3, 1, 3'd1, 0, 8'h00, 0, "R11");
    step(1, 1, 3, 1, 3'd1, 0, 8'h00, 0, "R11");
    step(0, 0, 3, 1, 3'd0, 0, 8'h00, 0, "R4");
    step(0, 1, 3, 1, 3'd0, 0, 8'h77, 0, "R12");
    step(0, 1, 3, 1, 3'd0, 1, 8'h12, 0, "R12");
    step(0, 1, 3, 0, 3'd0, 0, 8'h77, 0, "R12");
    rd_all("R2");
    do_reset(1'b1);
    rd_all("R1");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule